// File: doc/BRIEF.md
# Serial-to-Parallel TDM De-interleaver

This block takes a bundle of serial time-division multiplexed streams and reassembles their channels onto an 8-bit parallel TDM bus. There are two line rates. At the low rate, 32 streams each carry 32 channels. At the high rate, 16 streams each carry 64 channels. In both cases a frame holds 1024 channels and spans 2048 master clocks. Each parallel slot lasts two master clocks.

The parallel bus walks across the streams first and the channels second. Every stream is sampled at the same time into its own shift register. At the end of each serial channel, all the finished bytes move together into a holding bank. That bank is then read out, one stream per slot, during the next channel time. The bus can be enabled for the whole slot or for a one-clock window between two falling edges. A delay select moves all slot timing one master clock later. An asynchronous disable releases the bus at once.

A frame strobe, sampled on a rising clock edge, marks the frame boundary. The bus stays disabled until the first strobe has been seen. A later strobe realigns the timing.

Top module: `tdm_deinterleaver`

## Requirements
- R1: In low-rate mode (`rate_hi`=0), slot n of the frame carries stream n mod 32, channel n div 32. The byte that stream s received in channel c is on `par_data` for the two clocks that begin at the rising edge 64(c+1)+2s+1 clocks after the frame-boundary edge, counted modulo 2048.
- R2: In high-rate mode (`rate_hi`=1), 16 streams of 64 channels are used. The byte from stream s, channel c is presented for two clocks beginning 32(c+1)+2s+1 clocks after the boundary edge, modulo 2048.
- R3: Each serial channel is 8 bits long and arrives most significant bit first. Bit i of a channel, counting i=0 as the first bit, lands in byte bit 7-i. Bits are 8 clocks wide at the low rate and 4 clocks wide at the high rate, and they are aligned to the boundary edge.
- R4: With `wide_drive`=1, `par_oe` stays high for the entire slot once a frame strobe has been seen. `par_data` changes only on the first rising edge of a slot.
- R5: With `wide_drive`=0, `par_oe` rises on the falling edge in the middle of a slot's first clock. It falls on the next falling edge.
- R6: With `late_timing`=1, every slot boundary from R1, R2 and R5 occurs one master clock later.
- R7: `out_dis`=1 forces `par_oe` low at once, with no clock edge needed. Clearing it restores the enable, again without a clock edge.
- R8: In high-rate mode, streams 16 to 31 have no effect on `par_data`.
- R9: While reset is held, `par_data` is 0 and `par_oe` is 0. After reset, `par_oe` stays 0 until the first frame strobe.
- R10: A frame strobe in mid-frame realigns slot timing to the new boundary edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; two clocks per parallel slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame-boundary strobe, sampled on the rising edge |
| rate_hi | input | 1 | 0: 32 streams × 32 channels; 1: 16 streams × 64 channels |
| wide_drive | input | 1 | 1: drive the whole slot; 0: drive a one-clock window |
| late_timing | input | 1 | 1: shift all slot timing one clock later |
| out_dis | input | 1 | Asynchronous bus disable |
| ser_in | input | 32 | Serial input streams, one bit each |
| par_data | output | 8 | Parallel slot byte |
| par_oe | output | 1 | Tri-state enable for the parallel bus |

## Verification
The hardest conditions to reach from the ports are the half-clock enable window and the asynchronous disable. Neither can be seen at rising-edge sample points. The bench therefore samples each clock twice: a quarter period after the rising edge and a quarter period after the falling edge. It also toggles `out_dis` between edges and checks the enable before the next edge arrives.

Stream-to-slot mapping and latency are checked across a full frame wrap. This covers channel 31 (or 63), which is presented in the following frame. At the high rate, the upper streams carry noise that differs from their low-rate pattern, so any leak of those streams into the output shows up in the data.

// File: rtl/tdm_s2p_pkg.sv
`timescale 1ns/1ps
package tdm_s2p_pkg;

  typedef enum logic {RATE_LOW = 1'b0, RATE_HIGH = 1'b1} rate_e;

  // master clocks per serial channel time for the selected rate
  function automatic int unsigned chan_clocks(int unsigned streams, logic hi);
    return hi ? streams : 2 * streams;
  endfunction

  // sampling point in the middle of a serial bit cell
  function automatic logic is_mid_bit(int unsigned pos, int unsigned bitclk);
    return (pos % bitclk) == (bitclk / 2);
  endfunction

  // last master clock of a serial channel time
  function automatic logic is_chan_last(int unsigned pos, int unsigned chclk);
    return pos == (chclk - 1);
  endfunction

endpackage

// File: rtl/s2p_frame_timer.sv
`timescale 1ns/1ps
module s2p_frame_timer #(
  parameter int unsigned FRAME_CLK = 2048,
  parameter int unsigned CW        = $clog2(FRAME_CLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  input  logic          late_timing,
  output logic [CW-1:0] cnt,
  output logic          locked
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CLK - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (frame_sync) begin
      cnt    <= late_timing ? LAST : '0;
      locked <= 1'b1;
    end else begin
      cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/s2p_slot_decode.sv
`timescale 1ns/1ps
module s2p_slot_decode
  import tdm_s2p_pkg::*;
#(
  parameter int unsigned STREAMS = 32,
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned CW      = 11,
  parameter int unsigned SW      = $clog2(STREAMS)
) (
  input  logic [CW-1:0] cnt,
  input  logic          hi,
  output logic          sample_stb,
  output logic          chan_last,
  output logic [SW-1:0] rd_stream,
  output logic          out_first
);
  localparam int unsigned CH_LO  = 2 * STREAMS;
  localparam int unsigned CH_HI  = STREAMS;
  localparam int unsigned BIT_LO = CH_LO / WIDTH;
  localparam int unsigned BIT_HI = CH_HI / WIDTH;
  localparam int unsigned PW     = $clog2(CH_LO);

  logic [PW-1:0] pos;
  int unsigned   pos_i;
  int unsigned   bitclk;
  int unsigned   chclk;

  assign pos = hi ? {1'b0, cnt[PW-2:0]} : cnt[PW-1:0];

  always_comb begin
    pos_i      = 32'(pos);
    bitclk     = hi ? BIT_HI : BIT_LO;
    chclk      = chan_clocks(STREAMS, hi);
    sample_stb = is_mid_bit(pos_i, bitclk);
    chan_last  = is_chan_last(pos_i, chclk);
  end

  // each parallel slot spans two counts; stream index is the count halved
  assign rd_stream = pos[PW-1:1];
  // odd count: first clock of the slot being presented
  assign out_first = pos[0];
endmodule

// File: rtl/s2p_serial_capture.sv
`timescale 1ns/1ps
module s2p_serial_capture #(
  parameter int unsigned STREAMS = 32,
  parameter int unsigned WIDTH   = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [STREAMS-1:0]              ser_in,
  input  logic                            sample_stb,
  input  logic                            chan_last,
  input  logic                            hi,
  output logic [STREAMS-1:0][WIDTH-1:0]   hold
);
  localparam int unsigned HALF = STREAMS / 2;

  for (genvar s = 0; s < STREAMS; s++) begin : g_lane
    logic [WIDTH-1:0] shreg;
    logic [WIDTH-1:0] bank;
    logic             lane_on;

    if (s < HALF) begin : g_always
      assign lane_on = 1'b1;
    end else begin : g_low_only
      assign lane_on = ~hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shreg <= '0;
        bank  <= '0;
      end else begin
        if (sample_stb && lane_on) shreg <= {shreg[WIDTH-2:0], ser_in[s]};
        if (chan_last && lane_on)  bank  <= shreg;
      end
    end

    assign hold[s] = bank;
  end
endmodule

// File: rtl/s2p_slot_reader.sv
`timescale 1ns/1ps
module s2p_slot_reader #(
  parameter int unsigned STREAMS = 32,
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned SW      = $clog2(STREAMS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [STREAMS-1:0][WIDTH-1:0] hold,
  input  logic [SW-1:0]                 rd_stream,
  input  logic                          out_first,
  output logic [WIDTH-1:0]              par_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          par_data <= '0;
    else if (!out_first) par_data <= hold[rd_stream];
  end
endmodule

// File: rtl/s2p_drive_ctrl.sv
`timescale 1ns/1ps
module s2p_drive_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic locked,
  input  logic out_first,
  input  logic wide_drive,
  input  logic out_dis,
  output logic narrow_en,
  output logic par_oe
);
  // half-slot window: opened and closed on falling edges
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) narrow_en <= 1'b0;
    else        narrow_en <= locked & out_first;
  end

  assign par_oe = ~out_dis & (wide_drive ? locked : narrow_en);
endmodule

// File: rtl/tdm_deinterleaver.sv
`timescale 1ns/1ps
module tdm_deinterleaver
  import tdm_s2p_pkg::*;
#(
  parameter int unsigned STREAMS  = 32,
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned TOTAL_CH = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_sync,
  input  logic               rate_hi,
  input  logic               wide_drive,
  input  logic               late_timing,
  input  logic               out_dis,
  input  logic [STREAMS-1:0] ser_in,
  output logic [WIDTH-1:0]   par_data,
  output logic               par_oe
);
  localparam int unsigned FRAME_CLK = 2 * TOTAL_CH;
  localparam int unsigned CW        = $clog2(FRAME_CLK);
  localparam int unsigned SW        = $clog2(STREAMS);

  rate_e                        rate_sel;
  logic                         hi;
  logic [CW-1:0]                cnt;
  logic                         locked;
  logic                         sample_stb;
  logic                         chan_last;
  logic [SW-1:0]                rd_stream;
  logic                         out_first;
  logic                         narrow_en;
  logic [STREAMS-1:0][WIDTH-1:0] hold;

  assign rate_sel = rate_e'(rate_hi);
  assign hi       = (rate_sel == RATE_HIGH);

  s2p_frame_timer #(.FRAME_CLK(FRAME_CLK), .CW(CW)) i_timer (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .late_timing(late_timing), .cnt(cnt), .locked(locked)
  );

  s2p_slot_decode #(.STREAMS(STREAMS), .WIDTH(WIDTH), .CW(CW), .SW(SW)) i_decode (
    .cnt(cnt), .hi(hi), .sample_stb(sample_stb), .chan_last(chan_last),
    .rd_stream(rd_stream), .out_first(out_first)
  );

  s2p_serial_capture #(.STREAMS(STREAMS), .WIDTH(WIDTH)) i_capture (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sample_stb(sample_stb),
    .chan_last(chan_last), .hi(hi), .hold(hold)
  );

  s2p_slot_reader #(.STREAMS(STREAMS), .WIDTH(WIDTH), .SW(SW)) i_reader (
    .clk(clk), .rst_n(rst_n), .hold(hold), .rd_stream(rd_stream),
    .out_first(out_first), .par_data(par_data)
  );

  s2p_drive_ctrl i_drive (
    .clk(clk), .rst_n(rst_n), .locked(locked), .out_first(out_first),
    .wide_drive(wide_drive), .out_dis(out_dis), .narrow_en(narrow_en),
    .par_oe(par_oe)
  );
endmodule

// File: rtl/tdm_s2p_checker.sv
`timescale 1ns/1ps
module tdm_s2p_checker #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned CW    = 11,
  parameter int unsigned SW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_sync,
  input logic             late_timing,
  input logic             rate_hi,
  input logic             wide_drive,
  input logic             out_dis,
  input logic [CW-1:0]    cnt,
  input logic             locked,
  input logic             out_first,
  input logic             chan_last,
  input logic [SW-1:0]    rd_stream,
  input logic [WIDTH-1:0] par_data,
  input logic             par_oe
);
  // R4
  slot_data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |=> $stable(par_data));

  // R6
  boundary_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync ##1 !frame_sync) |=> (cnt == (late_timing ? CW'(0) : CW'(1))));

  // R1
  bank_first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_last && !frame_sync) |=> (rd_stream == '0));

  // R8
  upper_streams_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_hi |-> (rd_stream[SW-1] == 1'b0));

  // R5
  narrow_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_drive && !out_dis && locked) |-> (par_oe == out_first));
endmodule

bind tdm_deinterleaver tdm_s2p_checker #(.WIDTH(WIDTH), .CW(CW), .SW(SW)) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .late_timing(late_timing),
  .rate_hi(rate_hi), .wide_drive(wide_drive), .out_dis(out_dis), .cnt(cnt),
  .locked(locked), .out_first(out_first), .chan_last(chan_last),
  .rd_stream(rd_stream), .par_data(par_data), .par_oe(par_oe)
);

// File: tb/test_tdm_deinterleaver.sv
`timescale 1ns/1ps
module test_tdm_deinterleaver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic        rate_hi = 1'b0;
  logic        wide_drive = 1'b1;
  logic        late_timing = 1'b0;
  logic        out_dis = 1'b0;
  logic [31:0] ser_in = '0;
  logic [7:0]  par_data;
  logic        par_oe;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  tdm_deinterleaver i_tdm_deinterleaver (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rate_hi(rate_hi),
    .wide_drive(wide_drive), .late_timing(late_timing), .out_dis(out_dis),
    .ser_in(ser_in), .par_data(par_data), .par_oe(par_oe)
  );

  // {rate_hi, wide_drive, late_timing, seed}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b0, 8'd11}, {1'b0, 1'b0, 1'b0, 8'd22},
    {1'b0, 1'b1, 1'b1, 8'd33}, {1'b0, 1'b0, 1'b1, 8'd44},
    {1'b1, 1'b1, 1'b0, 8'd55}, {1'b1, 1'b0, 1'b0, 8'd66},
    {1'b1, 1'b0, 1'b1, 8'd77}, {1'b1, 1'b1, 1'b1, 8'd88}
  };

  function automatic logic [7:0] pat(int s, int c, int seed);
    return 8'((s * 29 + c * 13 + seed * 7) & 255);
  endfunction

  // byte expected on the bus in the clock after boundary-relative edge k
  function automatic logic [7:0] exp_byte(int k, logic hi, logic late, int seed);
    int m, ma, ct, s, c;
    m  = (((k - 1 - int'(late)) % 2048) + 2048) % 2048;
    ma = m & ~1;
    if (hi) begin
      ct = ma / 32; s = (ma % 32) / 2; c = (ct + 63) % 64;
    end else begin
      ct = ma / 64; s = (ma % 64) / 2; c = (ct + 31) % 32;
    end
    return pat(s, c, seed);
  endfunction

  task automatic drive_serial(int k, logic hi, int seed);
    int a;
    logic [7:0] b;
    a = k % 2048;
    for (int s = 0; s < 32; s++) begin
      if (!hi) begin
        b = pat(s, a / 64, seed);
        ser_in[s] = b[7 - (a % 64) / 8];
      end else if (s < 16) begin
        b = pat(s, a / 32, seed);
        ser_in[s] = b[7 - (a % 32) / 4];
      end else begin
        ser_in[s] = ((k * 5 + s * 3) % 7) < 3;
      end
    end
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, expv, $time);
    end
  endtask

  task automatic run(logic hi, logic wide, logic late, int seed, int kmax, string extra);
    string dtag;
    int    m;
    rate_hi = hi; wide_drive = wide; late_timing = late;
    dtag = $sformatf("%s%s%s", hi ? "R2 R3 R8" : "R1 R3", late ? " R6" : "", extra);
    @(posedge clk); #1 frame_sync = 1'b1;
    for (int k = 0; k < kmax; k++) begin
      @(posedge clk); #1 frame_sync = 1'b0;
      drive_serial(k, hi, seed);
      #1;
      m = (((k - 1 - int'(late)) % 2048) + 2048) % 2048;
      if (k >= 2112) begin
        chk({dtag, " data R4"}, par_data, exp_byte(k, hi, late, seed));
        if (wide) chk({dtag, " oe R4"}, {7'd0, par_oe}, 8'd1);
        else      chk({dtag, " oe rise R5"}, {7'd0, par_oe}, {7'd0, (m & 1) == 1});
      end
      #4;
      if (k >= 2112 && !wide)
        chk({dtag, " oe fall R5"}, {7'd0, par_oe}, {7'd0, (m & 1) == 0});
    end
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: reset state, then idle before the first strobe
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset data", par_data, 8'h00);
    chk("R9 reset oe", {7'd0, par_oe}, 8'h00);
    #1 rst_n = 1'b1;
    repeat (40) begin
      @(posedge clk); #2;
      chk("R9 idle oe", {7'd0, par_oe}, 8'h00);
    end

    foreach (VEC[i]) begin
      @(posedge clk); #1 rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      run(VEC[i][10], VEC[i][9], VEC[i][8], int'(VEC[i][7:0]), 4160, "");
    end

    // R10: strobe at an arbitrary phase without reset
    repeat (777) @(posedge clk);
    run(1'b0, 1'b1, 1'b0, 99, 4160, " R10");

    // R7: disable and re-enable between clock edges
    @(posedge clk); #1 out_dis = 1'b1;
    #0.5 chk("R7 async off", {7'd0, par_oe}, 8'h00);
    #1 out_dis = 1'b0;
    #0.5 chk("R7 async on", {7'd0, par_oe}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule